// File: doc/BRIEF.md
# NAND Flash Command/Address Sequencer

This block turns a one-hot operation code into the command and address byte cycles that a raw NAND flash device expects on its 8-bit bus. A register write supplies the code. The sequencer first places a command byte on the bus with the command-latch strobe. It then sends the address bytes for that operation with the address-latch strobe and, for operations that need one, a second command byte. Every bus cycle lasts one clock and is followed by one idle clock. A busy flag covers the whole burst of cycles.

Operations that carry data (reads, status, identification, features, page program) stay pending until the data path reports that its phase has ended. At that point a page program sends its closing command byte. Reset and block erase finish as soon as their last byte has gone out. A second entry point runs a spare-area sequence. It takes its two command bytes and its address-cycle count from a separate register, and it takes its first four address bytes from the ECC register.

Top module: `nand_cmd_seq`

## Requirements
- R1: After reset no strobe is active, busy, done and overrun are low, no operation is pending, and chip enable 0 is selected (nand_ce_n = 1110).
- R2: A write of one of the supported one-hot codes, made while nothing is pending and the sequencer is idle, becomes the pending operation. The supported codes are bit 0 page read, 2 block erase, 3 status, 4 page program, 6 identify, 7 parameter page, 8 reset, 9 get features, 10 set features and 12 enhanced status. Any other nonzero value is ignored: it causes no strobe and does not change the pending operation.
- R3: A nonzero write while an operation is pending is rejected. The pending value stays the same and no strobe follows.
- R4: The first bus cycle appears in the clock after the write. It carries command byte 1 (cmd_reg[7:0]) with nand_cle high. Each cycle lasts one clock and is followed by one idle clock.
- R5: Address cycles 0 to 3 carry addr1_reg bytes 0 to 3, least significant byte first. Address cycle 4 carries addr2_reg[7:0]. All address cycles have nand_ale high.
- R6: The number of address cycles is fixed per operation: reset 0, status 0, identify 1, parameter page 1, get/set features 1, enhanced status 3, block erase 3, page read 5, page program 5.
- R7: Page read and block erase send command byte 2 (cmd_reg[15:8]) with nand_cle directly after their address cycles.
- R8: Reset and block erase complete on their own. The pending operation clears, and xfer_done pulses for one clock in the cycle after the last strobe, while busy is low.
- R9: The other operations stay pending until phase_done. Page program then sends command byte 2 (latched at the write) and pulses xfer_done in the clock after that cycle. All other pending operations pulse xfer_done in the clock after phase_done. phase_done has no effect when nothing is pending.
- R10: The chip select is addr2_reg[31:30], captured when the operation is accepted. It drives nand_ce_n active low and one-hot, and later changes to addr2_reg have no effect on it.
- R11: spare_go runs spare command byte 1 (spare_reg[7:0]), then spare_reg[30:28] address cycles taken from ecc_reg bytes 0 to 3 and then addr2_reg[7:0], then spare command byte 2 (spare_reg[15:8]). It does not touch the pending operation and does not pulse xfer_done. A count above 5 sends only 5 address cycles and pulses addr_overrun for one clock.
- R12: A zero write while the sequencer is idle clears the pending operation without any strobe or done pulse. Any program write while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| prog_wr | input | 1 | Program register write strobe |
| prog_wdata | input | 16 | One-hot operation code being written |
| cmd_reg | input | 32 | Command bytes 1 [7:0] and 2 [15:8] |
| addr1_reg | input | 32 | Address bytes 0 to 3 |
| addr2_reg | input | 32 | Address byte 4 [7:0], chip select [31:30] |
| spare_go | input | 1 | Start a spare-area sequence |
| spare_reg | input | 32 | Spare command bytes [7:0], [15:8], cycle count [30:28] |
| ecc_reg | input | 32 | Spare address bytes 0 to 3 |
| phase_done | input | 1 | Data phase of the pending operation has ended |
| nand_cle | output | 1 | Command-latch strobe |
| nand_ale | output | 1 | Address-latch strobe |
| nand_stb | output | 1 | A bus byte cycle is active |
| nand_io | output | 8 | Bus byte |
| nand_ce_n | output | 4 | Active-low chip enables |
| busy | output | 1 | Byte cycles in progress |
| xfer_done | output | 1 | Operation completion pulse |
| addr_overrun | output | 1 | Spare cycle count above five |
| op_pending | output | 16 | Pending operation code |

## Verification
Assertions check the bus timing rules on every clock. No cycle runs directly after another, each burst opens with a command-latch cycle, a burst never carries more than five address cycles, the pending code is at most one-hot, completion never coincides with a pending code, and a rejected write leaves the pending code unchanged. The byte values, their order, the per-operation cycle counts, the timing of the done pulse relative to the last cycle, chip-select capture and the spare-area path all depend on register contents. Only the directed scenarios can show these, by comparing the observed bus log with the bytes computed from the requirements.

// File: rtl/nand_seq_pkg.sv
// Shared constants and types for the NAND command/address sequencer.
// Assumes at most five address cycles and a 16-bit operation code.
package nand_seq_pkg;
    localparam int PROG_W    = 16;
    localparam int ADDR_MAX  = 5;
    localparam int CNT_W     = 3;
    localparam int LO_BYTES  = 4;
    localparam int SLOTS     = 2 ** CNT_W;

    localparam int OP_READ       = 0;
    localparam int OP_ERASE      = 2;
    localparam int OP_STATUS     = 3;
    localparam int OP_PROGRAM    = 4;
    localparam int OP_READ_ID    = 6;
    localparam int OP_PARAM      = 7;
    localparam int OP_RESET      = 8;
    localparam int OP_GET_FEAT   = 9;
    localparam int OP_SET_FEAT   = 10;
    localparam int OP_STATUS_ENH = 12;

    typedef struct packed {
        logic             valid;
        logic [CNT_W-1:0] n_addr;
        logic             cmd2_now;
        logic             instant;
    } op_attr_t;

    typedef enum logic [1:0] {SRC_MAIN, SRC_SPARE, SRC_TAIL} seq_src_e;
endpackage

// File: rtl/nand_op_decode.sv
// Maps a one-hot operation code onto its address-cycle count, its
// second-command rule and whether it completes without a data phase.
// Assumes anything not in the table is unsupported (valid = 0).
module nand_op_decode
    import nand_seq_pkg::*;
(
    input  logic [PROG_W-1:0] code,
    output op_attr_t          attr
);
    localparam logic [PROG_W-1:0] ONE = 1;

    // Table lookup of per-operation attributes
    always_comb begin
        attr = '0;
        case (code)
            ONE << OP_READ:       attr = '{1'b1, 3'd5, 1'b1, 1'b0};
            ONE << OP_ERASE:      attr = '{1'b1, 3'd3, 1'b1, 1'b1};
            ONE << OP_STATUS:     attr = '{1'b1, 3'd0, 1'b0, 1'b0};
            ONE << OP_PROGRAM:    attr = '{1'b1, 3'd5, 1'b0, 1'b0};
            ONE << OP_READ_ID:    attr = '{1'b1, 3'd1, 1'b0, 1'b0};
            ONE << OP_PARAM:      attr = '{1'b1, 3'd1, 1'b0, 1'b0};
            ONE << OP_RESET:      attr = '{1'b1, 3'd0, 1'b0, 1'b1};
            ONE << OP_GET_FEAT:   attr = '{1'b1, 3'd1, 1'b0, 1'b0};
            ONE << OP_SET_FEAT:   attr = '{1'b1, 3'd1, 1'b0, 1'b0};
            ONE << OP_STATUS_ENH: attr = '{1'b1, 3'd3, 1'b0, 1'b0};
            default:              attr = '0;
        endcase
    end
endmodule

// File: rtl/nand_addr_pick.sv
// Builds the ordered address byte slots: the low register supplies
// slots 0..LO_BYTES-1 (LSB first), the high register's low byte fills
// the next slot, remaining slots read zero.
module nand_addr_pick
    import nand_seq_pkg::*;
(
    input  logic [31:0]            lo_word,
    input  logic [31:0]            hi_word,
    output logic [SLOTS-1:0][7:0]  bytes
);
    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        if (g < LO_BYTES) begin : g_lo
            assign bytes[g] = lo_word[8*g +: 8];
        end else if (g == LO_BYTES) begin : g_hi
            assign bytes[g] = hi_word[7:0];
        end else begin : g_zero
            assign bytes[g] = 8'h00;
        end
    end
endmodule

// File: rtl/nand_strobe_seq.sv
// Cycle engine: on launch it captures the bytes of one burst and plays
// command 1, n address bytes and optionally command 2, one clock per
// byte with a one-clock gap. A tail launch plays only command 2.
// Assumes launch is never raised while active.
module nand_strobe_seq
    import nand_seq_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   launch,
    input  logic [CNT_W-1:0]       l_n_addr,
    input  logic                   l_cmd2,
    input  logic                   l_tail,
    input  logic [7:0]             l_c1,
    input  logic [7:0]             l_c2,
    input  logic [SLOTS-1:0][7:0]  l_bytes,
    output logic                   stb,
    output logic                   cle,
    output logic                   ale,
    output logic [7:0]             io,
    output logic                   active,
    output logic                   last_stb
);
    logic                  active_q, gap_q, cmd2_q, tail_q;
    logic [CNT_W-1:0]      idx_q, nadr_q;
    logic [7:0]            c1_q, c2_q;
    logic [SLOTS-1:0][7:0] ab_q;
    logic [CNT_W:0]        last_idx;
    logic [CNT_W-1:0]      aidx;
    logic                  is_c1, is_adr, is_last;

    // Decode which kind of byte the current slot carries
    always_comb begin
        last_idx = {1'b0, nadr_q} + {{CNT_W{1'b0}}, cmd2_q};
        is_last  = tail_q || ({1'b0, idx_q} == last_idx);
        is_c1    = !tail_q && (idx_q == '0);
        is_adr   = !tail_q && (idx_q != '0) && (idx_q <= nadr_q);
        aidx     = idx_q - 1'b1;
    end

    // Step through slots with an idle gap between bytes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            gap_q    <= 1'b0;
            idx_q    <= '0;
            nadr_q   <= '0;
            cmd2_q   <= 1'b0;
            tail_q   <= 1'b0;
            c1_q     <= '0;
            c2_q     <= '0;
            ab_q     <= '0;
        end else if (launch) begin
            active_q <= 1'b1;
            gap_q    <= 1'b0;
            idx_q    <= '0;
            nadr_q   <= l_n_addr;
            cmd2_q   <= l_cmd2;
            tail_q   <= l_tail;
            c1_q     <= l_c1;
            c2_q     <= l_c2;
            ab_q     <= l_bytes;
        end else if (active_q) begin
            if (!gap_q) begin
                if (is_last) active_q <= 1'b0;
                else         gap_q    <= 1'b1;
            end else begin
                gap_q <= 1'b0;
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    // Drive the bus from the current slot
    always_comb begin
        stb      = active_q && !gap_q;
        cle      = stb && !is_adr;
        ale      = stb && is_adr;
        io       = !stb ? 8'h00 : is_c1 ? c1_q : is_adr ? ab_q[aidx] : c2_q;
        active   = active_q;
        last_stb = stb && is_last;
    end

    // R4: a byte cycle is always followed by an idle clock
    p_gap_after_byte_r4: assert property (@(posedge clk) disable iff (!rst_n)
        stb |=> !stb);

    // R4: each burst opens with a command-latch cycle
    p_burst_opens_cle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active_q) |-> cle);
endmodule

// File: rtl/nand_cmd_seq.sv
// Top of the NAND command/address sequencer. Holds the pending
// operation code, accepts or rejects program writes, chooses what
// the cycle engine plays (main operation, spare-area burst, or the
// closing command of a page program) and raises completion.
// Assumes the data path signals phase_done once per pending operation.
module nand_cmd_seq
    import nand_seq_pkg::*;
#(
    parameter int NUM_CS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_wr,
    input  logic [15:0]       prog_wdata,
    input  logic [31:0]       cmd_reg,
    input  logic [31:0]       addr1_reg,
    input  logic [31:0]       addr2_reg,
    input  logic              spare_go,
    input  logic [31:0]       spare_reg,
    input  logic [31:0]       ecc_reg,
    input  logic              phase_done,
    output logic              nand_cle,
    output logic              nand_ale,
    output logic              nand_stb,
    output logic [7:0]        nand_io,
    output logic [NUM_CS-1:0] nand_ce_n,
    output logic              busy,
    output logic              xfer_done,
    output logic              addr_overrun,
    output logic [15:0]       op_pending
);
    localparam int CS_W = 2;

    op_attr_t              attr;
    logic [PROG_W-1:0]     pend_q;
    logic                  instant_q, done_q, ovr_q;
    logic [CS_W-1:0]       cs_q;
    logic [7:0]            prog_c2_q;
    seq_src_e              src_q;
    logic [SLOTS-1:0][7:0] main_bytes, spare_bytes;
    logic                  active, last_stb;
    logic                  accept_new, clear_zero, phase_act, tail_launch;
    logic                  data_finish, spare_launch, launch;
    logic [CNT_W-1:0]      sp_n, sp_eff, l_n_addr;
    logic                  sp_over, l_cmd2, l_tail;
    logic [7:0]            l_c1, l_c2;
    logic [SLOTS-1:0][7:0] l_bytes;
    logic [3:0]            ale_cnt_q;

    nand_op_decode u_decode (.code(prog_wdata), .attr(attr));

    nand_addr_pick u_pick_main  (.lo_word(addr1_reg), .hi_word(addr2_reg), .bytes(main_bytes));
    nand_addr_pick u_pick_spare (.lo_word(ecc_reg),   .hi_word(addr2_reg), .bytes(spare_bytes));

    // Arbitrate program writes, data-phase end and spare requests
    always_comb begin
        accept_new   = prog_wr && attr.valid && (pend_q == '0) && !active;
        clear_zero   = prog_wr && (prog_wdata == '0) && !active;
        phase_act    = phase_done && !prog_wr && !active && (pend_q != '0);
        tail_launch  = phase_act && pend_q[OP_PROGRAM];
        data_finish  = phase_act && !pend_q[OP_PROGRAM];
        spare_launch = spare_go && !prog_wr && !phase_done && !active;
        launch       = accept_new || spare_launch || tail_launch;
        sp_n         = spare_reg[30:28];
        sp_over      = sp_n > CNT_W'(ADDR_MAX);
        sp_eff       = sp_over ? CNT_W'(ADDR_MAX) : sp_n;
    end

    // Select the burst description handed to the cycle engine
    always_comb begin
        if (spare_launch) begin
            l_n_addr = sp_eff;
            l_cmd2   = 1'b1;
            l_tail   = 1'b0;
            l_c1     = spare_reg[7:0];
            l_c2     = spare_reg[15:8];
            l_bytes  = spare_bytes;
        end else if (tail_launch) begin
            l_n_addr = '0;
            l_cmd2   = 1'b1;
            l_tail   = 1'b1;
            l_c1     = 8'h00;
            l_c2     = prog_c2_q;
            l_bytes  = '0;
        end else begin
            l_n_addr = attr.n_addr;
            l_cmd2   = attr.cmd2_now;
            l_tail   = 1'b0;
            l_c1     = cmd_reg[7:0];
            l_c2     = cmd_reg[15:8];
            l_bytes  = main_bytes;
        end
    end

    nand_strobe_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .launch   (launch),
        .l_n_addr (l_n_addr),
        .l_cmd2   (l_cmd2),
        .l_tail   (l_tail),
        .l_c1     (l_c1),
        .l_c2     (l_c2),
        .l_bytes  (l_bytes),
        .stb      (nand_stb),
        .cle      (nand_cle),
        .ale      (nand_ale),
        .io       (nand_io),
        .active   (active),
        .last_stb (last_stb)
    );

    // Pending operation, chip select and completion bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q    <= '0;
            instant_q <= 1'b0;
            done_q    <= 1'b0;
            ovr_q     <= 1'b0;
            cs_q      <= '0;
            prog_c2_q <= '0;
            src_q     <= SRC_MAIN;
        end else begin
            done_q <= 1'b0;
            ovr_q  <= spare_launch && sp_over;
            if (accept_new) begin
                pend_q    <= prog_wdata;
                instant_q <= attr.instant;
                cs_q      <= addr2_reg[31:30];
                prog_c2_q <= cmd_reg[15:8];
                src_q     <= SRC_MAIN;
            end else if (clear_zero) begin
                pend_q <= '0;
            end else if (spare_launch) begin
                cs_q  <= addr2_reg[31:30];
                src_q <= SRC_SPARE;
            end else if (tail_launch) begin
                src_q <= SRC_TAIL;
            end else if (data_finish) begin
                pend_q <= '0;
                done_q <= 1'b1;
            end
            if (last_stb && ((src_q == SRC_TAIL) || (src_q == SRC_MAIN && instant_q))) begin
                pend_q <= '0;
                done_q <= 1'b1;
            end
        end
    end

    for (genvar g = 0; g < NUM_CS; g++) begin : g_ce
        assign nand_ce_n[g] = (cs_q != CS_W'(g));
    end

    assign busy         = active;
    assign xfer_done    = done_q;
    assign addr_overrun = ovr_q;
    assign op_pending   = pend_q;

    // Count address cycles per burst for the limit check
    always_ff @(posedge clk) begin
        if (!rst_n || launch) ale_cnt_q <= '0;
        else if (nand_ale)    ale_cnt_q <= ale_cnt_q + 1'b1;
    end

    // R11: never more than five address cycles in one burst
    p_addr_limit_r11: assert property (@(posedge clk) disable iff (!rst_n)
        nand_ale |-> (ale_cnt_q < 4'(ADDR_MAX)));

    // R2: pending code is at most one-hot
    p_pending_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(op_pending));

    // R8: completion leaves nothing pending and nothing on the bus
    p_done_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |-> (op_pending == '0) && !busy);

    // R3: a nonzero write over a pending code while idle keeps it
    p_reject_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_wr && prog_wdata != '0 && op_pending != '0 && !busy)
        |=> (op_pending == $past(op_pending)));
endmodule

// File: tb/nand_cmd_seq_bench.sv
module nand_cmd_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        prog_wr = 1'b0;
    logic [15:0] prog_wdata = '0;
    logic [31:0] cmd_reg = 32'h0000_B2A1;
    logic [31:0] addr1_reg = 32'h4433_2211;
    logic [31:0] addr2_reg = 32'h8000_0055;
    logic        spare_go = 1'b0;
    logic [31:0] spare_reg = '0;
    logic [31:0] ecc_reg = 32'hDDCC_BBAA;
    logic        phase_done = 1'b0;
    logic        nand_cle, nand_ale, nand_stb, busy, xfer_done, addr_overrun;
    logic [7:0]  nand_io;
    logic [3:0]  nand_ce_n;
    logic [15:0] op_pending;

    nand_cmd_seq u_nand_cmd_seq (.*);

    always #4 clk = ~clk;

    int cyc = 0;
    int vectors = 0;
    int errors = 0;
    bit finished = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // bus log, sampled mid-cycle
    int   n_log = 0;
    logic [7:0] log_io [16];
    logic log_cle [16];
    logic log_ale [16];
    int   log_cyc [16];
    int   done_cnt = 0;
    int   done_cyc = 0;
    int   ovr_cnt = 0;

    always @(negedge clk) begin
        if (nand_stb && n_log < 16) begin
            log_io[n_log]  = nand_io;
            log_cle[n_log] = nand_cle;
            log_ale[n_log] = nand_ale;
            log_cyc[n_log] = cyc;
            n_log = n_log + 1;
        end
        if (xfer_done) begin
            done_cnt = done_cnt + 1;
            done_cyc = cyc;
        end
        if (addr_overrun) ovr_cnt = ovr_cnt + 1;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_log();
        n_log = 0; done_cnt = 0; ovr_cnt = 0;
    endtask

    task automatic write_prog(input logic [15:0] v, output int wc);
        @(negedge clk);
        prog_wr = 1'b1; prog_wdata = v; wc = cyc;
        @(negedge clk);
        prog_wr = 1'b0; prog_wdata = '0;
    endtask

    task automatic pulse_phase(output int pc);
        @(negedge clk);
        phase_done = 1'b1; pc = cyc;
        @(negedge clk);
        phase_done = 1'b0;
    endtask

    task automatic settle();
        repeat (18) @(negedge clk);
    endtask

    function automatic logic [7:0] exp_byte(int k, int n, logic [7:0] c1, logic [7:0] c2,
                                            logic [31:0] lo, logic [31:0] hi);
        if (k == 0) return c1;
        if (k <= n) return (k - 1 < 4) ? lo[8*(k-1) +: 8] : hi[7:0];
        return c2;
    endfunction

    // compare one burst against the expected byte sequence
    task automatic check_burst(input string req, input int first_cyc, input int n, input bit c2,
                               input logic [7:0] c1b, input logic [7:0] c2b,
                               input logic [31:0] lo, input logic [31:0] hi);
        int total = 1 + n + (c2 ? 1 : 0);
        check(n_log == total, {req, " cycle count"}, n_log, total);
        for (int k = 0; k < total && k < n_log; k++) begin
            bit is_a = (k >= 1 && k <= n);
            check(log_io[k] == exp_byte(k, n, c1b, c2b, lo, hi), {req, " byte"},
                  log_io[k], exp_byte(k, n, c1b, c2b, lo, hi));
            check(log_ale[k] == is_a && log_cle[k] == !is_a, {req, " strobe kind"},
                  {log_cle[k], log_ale[k]}, {!is_a, is_a});
            check(log_cyc[k] == first_cyc + 2*k, "R4 spacing", log_cyc[k], first_cyc + 2*k);
        end
    endtask

    task automatic t_reset();
        check(!busy && !nand_stb && !nand_cle && !nand_ale, "R1 idle bus", {busy, nand_stb}, 0);
        check(op_pending == 0 && !xfer_done && !addr_overrun, "R1 status", op_pending, 0);
        check(nand_ce_n == 4'b1110, "R1 chip enable", nand_ce_n, 4'b1110);
    endtask

    // generic operation scenario: R4 R5 R6 R7 R8 R9
    task automatic t_op(input int bitn, input int n, input bit c2now, input bit inst, input string req);
        int wc, pc;
        logic [15:0] code = 16'(1) << bitn;
        clear_log();
        write_prog(code, wc);
        settle();
        check_burst(req, wc + 1, n, c2now, cmd_reg[7:0], cmd_reg[15:8], addr1_reg, addr2_reg);
        check(!busy, {req, " busy released"}, busy, 0);
        if (inst) begin
            check(done_cnt == 1 && done_cyc == log_cyc[n_log-1] + 1, "R8 done timing",
                  done_cyc, log_cyc[n_log-1] + 1);
            check(op_pending == 0, "R8 pending cleared", op_pending, 0);
        end else begin
            check(done_cnt == 0 && op_pending == code, "R9 waits for data", op_pending, code);
            clear_log();
            pulse_phase(pc);
            settle();
            if (bitn == 4) begin
                check(n_log == 1 && log_cle[0] && log_io[0] == cmd_reg[15:8] && log_cyc[0] == pc + 1,
                      "R9 program closing command", log_io[0], cmd_reg[15:8]);
                check(done_cnt == 1 && done_cyc == pc + 2, "R9 program done", done_cyc, pc + 2);
            end else begin
                check(n_log == 0 && done_cnt == 1 && done_cyc == pc + 1, "R9 data done",
                      done_cyc, pc + 1);
            end
            check(op_pending == 0, "R9 pending cleared", op_pending, 0);
        end
    endtask

    task automatic t_reject();
        int wc;
        clear_log();
        write_prog(16'h0008, wc);
        settle();
        clear_log();
        write_prog(16'h0004, wc);
        settle();
        check(op_pending == 16'h0008 && n_log == 0, "R3 rejected write", op_pending, 16'h0008);
        pulse_phase(wc);
        settle();
        check(op_pending == 0, "R3 cleanup", op_pending, 0);
    endtask

    task automatic t_bad_codes();
        int wc;
        clear_log();
        write_prog(16'h0003, wc);
        settle();
        check(op_pending == 0 && n_log == 0, "R2 multi-bit ignored", op_pending, 0);
        write_prog(16'h0002, wc);
        settle();
        check(op_pending == 0 && n_log == 0, "R2 unsupported bit ignored", n_log, 0);
        pulse_phase(wc);
        settle();
        check(done_cnt == 0 && n_log == 0, "R9 phase_done idle no effect", done_cnt, 0);
    endtask

    task automatic t_zero_and_busy();
        int wc;
        clear_log();
        write_prog(16'h0040, wc);
        settle();
        clear_log();
        write_prog(16'h0000, wc);
        settle();
        check(op_pending == 0 && n_log == 0 && done_cnt == 0, "R12 zero write clears", op_pending, 0);
        clear_log();
        write_prog(16'h0004, wc);
        @(negedge clk); prog_wr = 1'b1; prog_wdata = 16'h0000;
        @(negedge clk); prog_wr = 1'b1; prog_wdata = 16'h0001;
        @(negedge clk); prog_wr = 1'b0; prog_wdata = '0;
        settle();
        check(n_log == 5 && done_cnt == 1 && op_pending == 0, "R12 writes while busy ignored",
              n_log, 5);
    endtask

    task automatic t_chip_select();
        int wc;
        addr2_reg = 32'hC000_0077;
        write_prog(16'h0100, wc);
        settle();
        check(nand_ce_n == 4'b0111, "R10 chip select 3", nand_ce_n, 4'b0111);
        addr2_reg = 32'h4000_0077;
        settle();
        check(nand_ce_n == 4'b0111, "R10 select held", nand_ce_n, 4'b0111);
        write_prog(16'h0100, wc);
        settle();
        check(nand_ce_n == 4'b1101, "R10 chip select 1", nand_ce_n, 4'b1101);
        addr2_reg = 32'h8000_0055;
    endtask

    task automatic t_spare(input int cnt);
        int sc;
        int n = (cnt > 5) ? 5 : cnt;
        spare_reg = {1'b0, 3'(cnt), 12'h000, 8'hE2, 8'hE1};
        clear_log();
        @(negedge clk); spare_go = 1'b1; sc = cyc;
        @(negedge clk); spare_go = 1'b0;
        settle();
        check_burst("R11 spare", sc + 1, n, 1'b1, 8'hE1, 8'hE2, ecc_reg, addr2_reg);
        check(done_cnt == 0 && op_pending == 0, "R11 no completion", done_cnt, 0);
        check(ovr_cnt == ((cnt > 5) ? 1 : 0), "R11 overrun pulse", ovr_cnt, (cnt > 5) ? 1 : 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=0", 1);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_op(8, 0, 0, 1, "R8 reset op");
        t_op(2, 3, 1, 1, "R7 erase");
        t_op(0, 5, 1, 0, "R5 page read");
        t_op(4, 5, 0, 0, "R6 page program");
        t_op(3, 0, 0, 0, "R6 status");
        t_op(12, 3, 0, 0, "R6 enhanced status");
        t_op(6, 1, 0, 0, "R6 identify");
        t_op(7, 1, 0, 0, "R6 parameter page");
        t_op(9, 1, 0, 0, "R6 get features");
        t_op(10, 1, 0, 0, "R6 set features");
        cmd_reg = 32'h0000_3C5A;
        addr1_reg = 32'h0F1E_2D3C;
        t_op(0, 5, 1, 0, "R5 page read pattern 2");
        t_reject();
        t_bad_codes();
        t_zero_and_busy();
        t_chip_select();
        t_spare(2);
        t_spare(7);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule